// File: doc/BRIEF.md
# Bus Access Breakpoint Comparator

This block observes each access on a processor bus and compares it with one programmed breakpoint. It raises a break pulse when the access falls on the programmed location, qualified by direction (read, write or either) and, optionally, by access size. In size-aware mode a hit means that the bytes covered by the access overlap the bytes covered by the programmed address and size. In size-blind mode only the address has to agree. Accesses on the external bus always use the size-blind comparison, and only the first beat of a burst is ever compared.

The programmed fields are plain inputs that the surrounding logic holds steady. The break output is registered and lasts one clock per matching access. Counting breakpoints, handling what follows a break, and any register access by software are outside this block.

Top module: `bus_brk_cmp`

## Requirements
- R1: `bp_rw_sel_i` selects the direction. 00 breaks on reads only (`acc_write_i`=0), 01 on writes only (`acc_write_i`=1), and 10 on either direction.
- R2: `bp_rw_sel_i` = 11 never produces a break.
- R3: When `bp_size_mask_i`=1, a break needs `acc_addr_i` equal to `bp_addr_i` in all bits. Both size codes are ignored.
- R4: When `bp_size_mask_i`=0 and `acc_ext_i`=0, a break needs the byte ranges of the access and of the breakpoint to overlap. Size code 01 is a byte (1 byte), 10 is a word (2 bytes) and 00 is a long-word (4 bytes). Each range starts at its address rounded down to a multiple of its size.
- R5: A word breakpoint at offset 2 of a long-word hits a word access at offset 2 and a long-word access at offset 0. It does not hit a word access at offset 0.
- R6: In overlap mode, size code 11 on either the access or the breakpoint never matches.
- R7: A beat with `acc_burst_i`=1 and `acc_first_i`=0 never breaks. A first beat (`acc_first_i`=1) is compared normally.
- R8: With `acc_ext_i`=1 the comparison behaves as if `bp_size_mask_i` were 1.
- R9: No break occurs unless `acc_addr_i[31:2]` equals `bp_addr_i[31:2]`.
- R10: `brk_o` goes high in the cycle after a valid matching access and lasts one clock per access. It stays low after any cycle with `acc_valid_i`=0.
- R11: Synchronous active-low reset clears `brk_o` and the internal burst-tracking flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | 32 | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | Access size code (01 byte, 10 word, 00 long-word) |
| acc_burst_i | input | 1 | Access is a beat of a burst |
| acc_first_i | input | 1 | Beat is the first of its burst |
| acc_ext_i | input | 1 | Access runs on the external bus |
| bp_addr_i | input | 32 | Programmed breakpoint address |
| bp_rw_sel_i | input | 2 | Direction selection |
| bp_size_mask_i | input | 1 | 1 = ignore sizes |
| bp_size_i | input | 2 | Programmed size code |
| brk_o | output | 1 | Registered break pulse |

## Verification
The overlap comparison is tested with every pair of access and breakpoint sizes at every byte offset inside one long-word. These sweeps separate true range overlap from plain address equality and from wrong rounding of a range. The same offsets are repeated with the size mask set and with the external flag set, which shows whether sizes are really ignored. Direction codes, burst beats, upper-address mismatches and idle cycles are mixed into one stream, so a qualifier that leaks from one access into the next is caught.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Size codes for access and breakpoint sizes.
  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_BAD  = 2'b11;

  typedef enum logic [1:0] {
    DIR_RD   = 2'b00,
    DIR_WR   = 2'b01,
    DIR_ANY  = 2'b10,
    DIR_NONE = 2'b11
  } dir_sel_e;

  // Byte lanes of a long-word touched by an access at offset off with size sz.
  // The offset is rounded down to the size.
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << off;
      SZ_WORD: m = off[1] ? 4'b1100 : 4'b0011;
      SZ_LONG: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic dir_ok(input logic [1:0] sel, input logic wr);
    logic ok;
    case (sel)
      DIR_RD:  ok = !wr;
      DIR_WR:  ok = wr;
      DIR_ANY: ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/brk_lanes.sv
module brk_lanes
  import brk_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0]      off_i,
  input  logic [1:0]            size_i,
  output logic [(1<<OFF_W)-1:0] lanes_o
);
  localparam int LANES = 1 << OFF_W;
  logic [3:0] m;
  always_comb m = lane_mask(off_i[1:0], size_i);
  assign lanes_o = LANES'(m);
endmodule

// File: rtl/brk_qual.sv
module brk_qual
  import brk_pkg::*;
(
  input  logic       valid_i,
  input  logic       write_i,
  input  logic       burst_i,
  input  logic       first_i,
  input  logic [1:0] sel_i,
  output logic       qual_o
);
  logic beat_ok;
  assign beat_ok = !burst_i || first_i;
  assign qual_o  = valid_i && beat_ok && dir_ok(sel_i, write_i);
endmodule

// File: rtl/bus_brk_cmp.sv
module bus_brk_cmp
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_burst_i,
  input  logic              acc_first_i,
  input  logic              acc_ext_i,
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic [1:0]        bp_rw_sel_i,
  input  logic              bp_size_mask_i,
  input  logic [1:0]        bp_size_i,
  output logic              brk_o
);
  localparam int LANES = 1 << OFF_W;

  // Named internal events, observed by the checker.
  logic             qual_w;
  logic             upper_eq_w;
  logic             exact_eq_w;
  logic             overlap_w;
  logic             blind_w;
  logic             hit_w;
  logic             burst_active_q;
  logic [LANES-1:0] lanes_w [2];

  brk_qual u_qual (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .burst_i (acc_burst_i),
    .first_i (acc_first_i),
    .sel_i   (bp_rw_sel_i),
    .qual_o  (qual_w)
  );

  // Side 0: the access, side 1: the breakpoint.
  for (genvar s = 0; s < 2; s++) begin : g_side
    brk_lanes #(.OFF_W(OFF_W)) u_lanes (
      .off_i   (s == 0 ? acc_addr_i[OFF_W-1:0] : bp_addr_i[OFF_W-1:0]),
      .size_i  (s == 0 ? acc_size_i : bp_size_i),
      .lanes_o (lanes_w[s])
    );
  end

  assign upper_eq_w = acc_addr_i[ADDR_W-1:OFF_W] == bp_addr_i[ADDR_W-1:OFF_W];
  assign exact_eq_w = upper_eq_w && (acc_addr_i[OFF_W-1:0] == bp_addr_i[OFF_W-1:0]);
  assign overlap_w  = upper_eq_w && |(lanes_w[0] & lanes_w[1]);
  assign blind_w    = bp_size_mask_i || acc_ext_i;
  assign hit_w      = qual_w && (blind_w ? exact_eq_w : overlap_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_o          <= 1'b0;
      burst_active_q <= 1'b0;
    end else begin
      brk_o <= hit_w;
      if (acc_valid_i) begin
        if (acc_burst_i && acc_first_i) burst_active_q <= 1'b1;
        else if (!acc_burst_i)          burst_active_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_brk_cmp_chk.sv
module bus_brk_cmp_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_write_i,
  input logic              acc_burst_i,
  input logic              acc_first_i,
  input logic [ADDR_W-1:0] bp_addr_i,
  input logic [1:0]        bp_rw_sel_i,
  input logic              hit_w,
  input logic              burst_active_q,
  input logic              brk_o
);
  AST_RESERVED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && bp_rw_sel_i == 2'b11) |=> !brk_o); // R2
  AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_rw_sel_i == 2'b00 && acc_write_i) |=> !brk_o); // R1
  AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_rw_sel_i == 2'b01 && !acc_write_i) |=> !brk_o); // R1
  AST_LATER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_burst_i && !acc_first_i) |=> !brk_o); // R7
  AST_BURST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_burst_i && acc_first_i) |=> burst_active_q); // R7
  AST_UPPER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr_i[ADDR_W-1:OFF_W] != bp_addr_i[ADDR_W-1:OFF_W]) |=> !brk_o); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !brk_o); // R10
  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> brk_o); // R10
endmodule

bind bus_brk_cmp bus_brk_cmp_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid_i    (acc_valid_i),
  .acc_addr_i     (acc_addr_i),
  .acc_write_i    (acc_write_i),
  .acc_burst_i    (acc_burst_i),
  .acc_first_i    (acc_first_i),
  .bp_addr_i      (bp_addr_i),
  .bp_rw_sel_i    (bp_rw_sel_i),
  .hit_w          (hit_w),
  .burst_active_q (burst_active_q),
  .brk_o          (brk_o)
);

// File: tb/bus_brk_cmp_tb.sv
module bus_brk_cmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_write_i = 1'b0;
  logic [1:0]  acc_size_i = 2'b00;
  logic        acc_burst_i = 1'b0;
  logic        acc_first_i = 1'b0;
  logic        acc_ext_i = 1'b0;
  logic [31:0] bp_addr_i = '0;
  logic [1:0]  bp_rw_sel_i = 2'b10;
  logic        bp_size_mask_i = 1'b0;
  logic [1:0]  bp_size_i = 2'b00;
  logic        brk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];

  bus_brk_cmp u_dut (.*);

  always #2 clk = ~clk;

  // Number of bytes for a size code, 0 for the unused code.
  function automatic int nbytes(input logic [1:0] sz);
    case (sz)
      2'b01: return 1;
      2'b10: return 2;
      2'b00: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit model(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                               input bit burst, input bit first, input bit ext, input bit v,
                               input logic [31:0] b, input logic [1:0] sel, input bit msk,
                               input logic [1:0] bsz);
    longint alo, ahi, blo, bhi;
    int na, nb;
    bit dirok;
    if (!v) return 0;
    if (burst && !first) return 0;
    dirok = (sel == 2'b00 && !wr) || (sel == 2'b01 && wr) || (sel == 2'b10);
    if (!dirok) return 0;
    if (msk || ext) return a == b;
    na = nbytes(sz); nb = nbytes(bsz);
    if (na == 0 || nb == 0) return 0;
    alo = longint'(a) - (longint'(a) % na); ahi = alo + na - 1;
    blo = longint'(b) - (longint'(b) % nb); bhi = blo + nb - 1;
    return (alo <= bhi) && (blo <= ahi);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: brk_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: applies one access for one cycle and queues its expected result.
  task automatic drive(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                       input bit burst, input bit first, input bit ext, input bit v,
                       input string tag);
    @(negedge clk);
    acc_addr_i = a; acc_write_i = wr; acc_size_i = sz; acc_burst_i = burst;
    acc_first_i = first; acc_ext_i = ext; acc_valid_i = v;
    sb.push_back('{model(a, wr, sz, burst, first, ext, v, bp_addr_i, bp_rw_sel_i,
                         bp_size_mask_i, bp_size_i), tag});
  endtask

  task automatic prog(input logic [31:0] b, input logic [1:0] sel, input bit msk,
                      input logic [1:0] bsz);
    @(negedge clk);
    acc_valid_i = 1'b0;
    bp_addr_i = b; bp_rw_sel_i = sel; bp_size_mask_i = msk; bp_size_i = bsz;
    sb.push_back('{1'b0, "R10 idle"});
  endtask

  // Monitor: result of the access driven before an edge appears after it.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(brk_o, it.exp, it.tag);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] szs [3] = '{2'b01, 2'b10, 2'b00};
    repeat (3) @(negedge clk);
    #1 check(brk_o, 1'b0, "R11 reset");
    // Break in reset must stay low (R11).
    acc_valid_i = 1; acc_addr_i = 0; acc_size_i = 2'b00;
    @(negedge clk); check(brk_o, 1'b0, "R11 in reset");
    acc_valid_i = 0;
    @(negedge clk); rst_n = 1'b1;

    // R5 worked example
    prog(32'h0000_1002, 2'b10, 0, 2'b10);
    drive(32'h0000_1002, 0, 2'b10, 0, 0, 0, 1, "R5 word@2");
    drive(32'h0000_1000, 0, 2'b00, 0, 0, 0, 1, "R5 long@0");
    drive(32'h0000_1000, 0, 2'b10, 0, 0, 0, 1, "R5 word@0 miss");
    drive(32'h0000_1003, 1, 2'b01, 0, 0, 0, 1, "R5 byte@3");

    // R4 / R6 sweep of all size pairs and offsets
    for (int bs = 0; bs < 4; bs++) begin
      for (int o = 0; o < 4; o++) begin
        prog(32'h00AB_CD00 | 32'(o), 2'b10, 0, 2'(bs));
        for (int as = 0; as < 4; as++)
          for (int ao = 0; ao < 4; ao++)
            drive(32'h00AB_CD00 | 32'(ao), as[0], 2'(as), 0, 0, 0, 1,
                  (as == 3 || bs == 3) ? "R6 bad size" : "R4 overlap");
      end
    end

    // R3 size mask and R8 external bus
    for (int o = 0; o < 4; o++) begin
      prog(32'h0000_2001, 2'b10, 1, 2'b01);
      drive(32'h0000_2000 | 32'(o), 0, 2'b00, 0, 0, 0, 1, "R3 masked");
      prog(32'h0000_2001, 2'b10, 0, 2'b01);
      drive(32'h0000_2000 | 32'(o), 0, 2'b00, 0, 0, 1, 1, "R8 external");
      drive(32'h0000_2000 | 32'(o), 0, 2'b00, 0, 0, 0, 1, "R4 internal");
    end

    // R1 / R2 direction selection
    for (int s = 0; s < 4; s++) begin
      prog(32'h0000_3000, 2'(s), 0, 2'b00);
      drive(32'h0000_3000, 0, 2'b00, 0, 0, 0, 1, s == 3 ? "R2 rd" : "R1 rd");
      drive(32'h0000_3000, 1, 2'b00, 0, 0, 0, 1, s == 3 ? "R2 wr" : "R1 wr");
    end

    // R7 bursts
    prog(32'h0000_4000, 2'b10, 0, 2'b00);
    drive(32'h0000_4000, 0, 2'b00, 1, 1, 0, 1, "R7 first beat");
    drive(32'h0000_4000, 0, 2'b00, 1, 0, 0, 1, "R7 later beat");
    drive(32'h0000_4000, 0, 2'b00, 1, 0, 0, 1, "R7 later beat");
    drive(32'h0000_4000, 0, 2'b00, 0, 0, 0, 1, "R7 single");

    // R9 upper bits, R10 idle and one-cycle pulse
    drive(32'h0000_4004, 0, 2'b00, 0, 0, 0, 1, "R9 next lword");
    drive(32'h8000_4000, 0, 2'b00, 0, 0, 1, 1, "R9 top bit");
    drive(32'h0000_4000, 0, 2'b00, 0, 0, 0, 0, "R10 no valid");
    drive(32'h0000_4000, 0, 2'b00, 0, 0, 0, 1, "R10 hit");
    drive(32'h0000_4001, 0, 2'b00, 0, 0, 0, 0, "R10 pulse ends");

    // R11 reset mid-run
    drive(32'h0000_4000, 0, 2'b00, 1, 1, 0, 1, "R11 pre-reset");
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    acc_valid_i = 0; rst_n = 0;
    @(negedge clk);
    check(brk_o, 1'b0, "R11 reset mid-run");
    rst_n = 1;
    drive(32'h0000_4000, 0, 2'b00, 0, 0, 0, 1, "R11 after reset");
    @(negedge clk); acc_valid_i = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule